// File: doc/BRIEF.md
# Sigma-Delta Bitstream Decimator

This block turns the one-bit output of an oversampling sigma-delta modulator into signed 16-bit PCM words, with the sample rate cut by 128. The design is three fixed stages in series. A fifth-order cascaded integrator-comb (CIC) section decimates by 32. Two seven-tap half-band FIR sections follow it, and each of them decimates by 2. The intended operating point is a 256 kHz bitstream with a 0 to 500 Hz signal band, which gives a 2 kHz output rate.

Each accepted bit is one input sample. The bit is accepted only in a cycle where `in_valid` is high. An output word appears together with a one-cycle `out_valid` pulse. `out_data` keeps that value until the next pulse. A synchronous reset returns every accumulator, delay element and phase counter to zero. After reset, the chain withholds its output until every stage has a full window of real data.

Top module: `sdm_decim`

## Requirements
- R1: A bit is taken only in a cycle where `in_valid` is 1. Bit 1 counts as +1 and bit 0 counts as -1. Cycles where `in_valid` is 0 leave the result unchanged, whatever `in_bit` carries.
- R2: The CIC is fifth order, with a comb delay of one decimated sample. It uses 27-bit wrap-around arithmetic. It produces a tick after every 32nd accepted bit, counted from reset, and the tick includes that bit. The first 5 ticks after reset are discarded. The CIC response equals five cascaded 32-sample running sums of the ±1 input, taken with zero history.
- R3: The CIC result c is scaled to 16 bits as floor((c + 512) / 1024), saturated to [-32768, 32767].
- R4: Each half-band stage has taps [-1024, 0, 9216, 16384, 9216, 0, -1024] / 32768 over its 7 newest inputs, newest first. It emits on every even-numbered input. The first emission is at its 8th input after reset.
- R5: Half-band sums are exact. Each result is floor((acc + 16384) / 32768), which rounds to nearest with ties toward +infinity, then saturated to [-32768, 32767].
- R6: No output appears before the 864th accepted bit after reset. After that, outputs follow at one per 128 accepted bits.
- R7: A constant all-ones stream gives 32767. A constant all-zeros stream gives -32768. A repeating 1,1,1,0 stream gives 16384.
- R8: An alternating 1,0 stream gives an output within ±4 of zero.
- R9: While reset is held, `out_valid` is 0 and `out_data` is 0. After reset, the same input stream reproduces the same outputs.
- R10: `out_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_bit` for this cycle |
| in_bit | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| out_valid | output | 1 | One-cycle strobe for a new output word |
| out_data | output | 16 | Signed PCM sample, held between strobes |

## Verification
The bench builds the block with its default parameters: fifth order, a CIC ratio of 32, two half-band stages and 16-bit words. With these values the 864-bit start-up gap and the 128:1 output spacing fit in a few thousand cycles. The defaults also make a full-scale stream drive the CIC to exactly +2^25, the one value that needs the 27th bit and triggers saturation after scaling. A running-sum model in the bench predicts every output word. Streams with idle gaps show that bits offered without `in_valid` change nothing.

// File: rtl/sdm_decim.sv
module sdm_decim #(
  parameter int ORDER = 5,
  parameter int LOG2R = 5,
  parameter int OUT_W = 16,
  parameter int NHB   = 2,
  parameter logic signed [15:0] HB_C0 = -16'sd1024,
  parameter logic signed [15:0] HB_C2 = 16'sd9216,
  parameter logic signed [15:0] HB_CC = 16'sd16384
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_bit,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int R     = 1 << LOG2R;
  localparam int CW    = 2 + ORDER * LOG2R;
  localparam int SH    = ORDER * LOG2R - (OUT_W - 1);
  localparam int TAPS  = 7;
  localparam int CNT_W = $clog2(TAPS);
  localparam int CF    = 15;
  localparam int AW    = 2 * OUT_W + 4;
  localparam int FW    = $clog2(ORDER + 1);
  localparam logic signed [AW-1:0] VMAX = AW'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [AW-1:0] VMIN = AW'(-(2 ** (OUT_W - 1)));

  function automatic logic signed [OUT_W-1:0] sat(input logic signed [AW-1:0] v);
    if (v > VMAX) return VMAX[OUT_W-1:0];
    if (v < VMIN) return VMIN[OUT_W-1:0];
    return v[OUT_W-1:0];
  endfunction

  logic signed [CW-1:0] integ   [ORDER];
  logic signed [CW-1:0] integ_n [ORDER];
  logic signed [CW-1:0] comb_d  [ORDER];
  logic signed [CW-1:0] comb_v  [ORDER];
  logic [LOG2R-1:0]     dec_cnt;
  logic [FW-1:0]        fill;
  logic                 cic_vld;
  logic signed [OUT_W-1:0] cic_q;
  logic                    sv [NHB+1];
  logic signed [OUT_W-1:0] sd [NHB+1];

  wire signed [CW-1:0] xin  = {{(CW-1){~in_bit}}, 1'b1};
  wire                 tick = in_valid && (dec_cnt == '1);

  always_comb begin
    integ_n[0] = integ[0] + xin;
    for (int k = 1; k < ORDER; k++) integ_n[k] = integ[k] + integ_n[k-1];
    comb_v[0] = integ_n[ORDER-1] - comb_d[0];
    for (int k = 1; k < ORDER; k++) comb_v[k] = comb_v[k-1] - comb_d[k];
  end

  wire signed [CW-1:0] cic_r = comb_v[ORDER-1] + CW'(1 <<< (SH - 1));
  wire signed [CW-1:0] cic_s = cic_r >>> SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ORDER; k++) begin
        integ[k]  <= '0;
        comb_d[k] <= '0;
      end
      dec_cnt <= '0;
      fill    <= '0;
      cic_vld <= 1'b0;
      cic_q   <= '0;
    end else begin
      cic_vld <= 1'b0;
      if (in_valid) begin
        for (int k = 0; k < ORDER; k++) integ[k] <= integ_n[k];
        dec_cnt <= dec_cnt + 1'b1;
        if (tick) begin
          comb_d[0] <= integ_n[ORDER-1];
          for (int k = 1; k < ORDER; k++) comb_d[k] <= comb_v[k-1];
          if (fill == FW'(ORDER)) begin
            cic_vld <= 1'b1;
            cic_q   <= sat(AW'(cic_s));
          end else begin
            fill <= fill + 1'b1;
          end
        end
      end
    end
  end

  assign sv[0] = cic_vld;
  assign sd[0] = cic_q;

  for (genvar s = 0; s < NHB; s++) begin : g_hb
    logic signed [OUT_W-1:0] tp [TAPS-1];
    logic                    ph;
    logic [CNT_W-1:0]        cnt;
    logic                    vo;
    logic signed [OUT_W-1:0] dq;
    logic signed [AW-1:0]    acc, rnd;

    assign acc = (AW'(sd[s]) + AW'(tp[5])) * AW'(HB_C0)
               + (AW'(tp[1]) + AW'(tp[3])) * AW'(HB_C2)
               + AW'(tp[2]) * AW'(HB_CC);
    assign rnd = (acc + AW'(1 <<< (CF - 1))) >>> CF;
    wire emit = sv[s] && ph && (cnt == CNT_W'(TAPS - 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < TAPS - 1; k++) tp[k] <= '0;
        ph  <= 1'b0;
        cnt <= '0;
        vo  <= 1'b0;
        dq  <= '0;
      end else begin
        vo <= 1'b0;
        if (sv[s]) begin
          tp[0] <= sd[s];
          for (int k = 1; k < TAPS - 1; k++) tp[k] <= tp[k-1];
          ph <= ~ph;
          if (cnt != CNT_W'(TAPS - 1)) cnt <= cnt + 1'b1;
          if (emit) begin
            vo <= 1'b1;
            dq <= sat(rnd);
          end
        end
      end
    end

    assign sv[s+1] = vo;
    assign sd[s+1] = dq;
  end

  assign out_valid = sv[NHB];
  assign out_data  = sd[NHB];
endmodule

// File: rtl/sdm_decim_chk.sv
module sdm_decim_chk #(
  parameter int LOG2R = 5,
  parameter int ORDER = 5,
  parameter int TAPS  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [LOG2R-1:0] dec_cnt,
  input logic             cic_vld,
  input logic             pre_vld
);
  localparam int FIRST = (1 << LOG2R) * (ORDER + 3 * (TAPS + 1) - 2);

  logic [31:0] nbits;
  always_ff @(posedge clk) begin
    if (rst) nbits <= '0;
    else if (in_valid && nbits != '1) nbits <= nbits + 1'b1;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(dec_cnt));

  // R2
  cic_tick_chk: assert property (@(posedge clk) disable iff (rst)
    cic_vld |-> ($past(in_valid) && $past(dec_cnt) == '1));

  // R4
  stage_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(pre_vld));

  // R6
  first_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (nbits >= 32'(FIRST)));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind sdm_decim sdm_decim_chk #(.LOG2R(LOG2R), .ORDER(ORDER), .TAPS(7)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .dec_cnt(dec_cnt), .cic_vld(cic_vld), .pre_vld(sv[NHB-1])
);

// File: tb/sdm_decim_tb.sv
`timescale 1ns/1ps
module sdm_decim_tb_top;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_bit = 1'b0;
  logic out_valid;
  logic signed [15:0] out_data;

  always #10 clk = ~clk;

  sdm_decim dut_i (.clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
                   .out_valid(out_valid), .out_data(out_data));

  int n_chk = 0, n_bad = 0;
  longint exp_q[$];
  longint last_out, min_out, max_out;
  int n_out, nb, nt, first_at, ms_pos;
  bit prev_v;
  longint ms_h [5][32];
  longint ms_r [5];
  longint hw [2][7];
  int hc [2];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < 5; k++) begin
      ms_r[k] = 0;
      for (int j = 0; j < 32; j++) ms_h[k][j] = 0;
    end
    for (int s = 0; s < 2; s++) begin
      hc[s] = 0;
      for (int j = 0; j < 7; j++) hw[s][j] = 0;
    end
    ms_pos = 0; nb = 0; nt = 0; n_out = 0; first_at = -1;
    min_out = 32767; max_out = -32768; last_out = 0;
  endtask

  function automatic bit hb_step(input int s, input longint x, output longint y);
    longint acc;
    for (int j = 6; j > 0; j--) hw[s][j] = hw[s][j-1];
    hw[s][0] = x;
    hc[s]++;
    y = 0;
    if (hc[s] % 2 == 0 && hc[s] >= 8) begin
      acc = -1024 * (hw[s][0] + hw[s][6]) + 9216 * (hw[s][2] + hw[s][4]) + 16384 * hw[s][3];
      y = sat16((acc + 16384) >>> 15);
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic model_bit(input bit b);
    longint v, old, q, y1, y2;
    v = b ? 1 : -1;
    for (int k = 0; k < 5; k++) begin
      old = ms_h[k][ms_pos];
      ms_h[k][ms_pos] = v;
      ms_r[k] += v - old;
      v = ms_r[k];
    end
    ms_pos = (ms_pos + 1) % 32;
    nb++;
    if (nb % 32 == 0) begin
      nt++;
      if (nt > 5) begin
        q = sat16((v + 512) >>> 10);
        if (hb_step(0, q, y1))
          if (hb_step(1, y1, y2)) exp_q.push_back(y2);
      end
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    model_bit(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_bit = lfsr[0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    chk(out_valid == 1'b0, "R9 valid in reset", longint'(out_valid), 0);
    chk(out_data == 16'sd0, "R9 data in reset", longint'(out_data), 0);
    model_clear();
    rst = 1'b0;
  endtask

  task automatic finish_pattern(input string req, input int pat);
    idle(12);
    chk(exp_q.size() == 0, "R6 all predicted outputs seen", exp_q.size(), 0);
    chk(first_at >= 864, "R6 first output position", first_at, 864);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (prev_v) chk(1'b0, "R10 back-to-back strobe", 1, 0);
        if (first_at < 0) first_at = nb;
        n_out++;
        last_out = out_data;
        if (out_data < min_out) min_out = out_data;
        if (out_data > max_out) max_out = out_data;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected output", longint'(out_data), 0);
        else begin
          longint e;
          e = exp_q.pop_front();
          // R2 R3 R4 R5: scoreboard against the running-sum model
          chk(longint'(out_data) == e, "R2/R3/R4/R5 sample", longint'(out_data), e);
        end
      end
      prev_v = out_valid;
    end else prev_v = 1'b0;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    prev_v = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    // R7: all ones
    for (int i = 0; i < 3000; i++) send(1'b1);
    finish_pattern("R7", 1);
    chk(last_out == 32767, "R7 all-ones value", last_out, 32767);
    chk(min_out == 32767, "R7 all-ones every sample", min_out, 32767);

    do_reset();
    // R7: all zeros
    for (int i = 0; i < 3000; i++) send(1'b0);
    finish_pattern("R7", 2);
    chk(last_out == -32768, "R7 all-zeros value", last_out, -32768);

    do_reset();
    // R8: alternating
    for (int i = 0; i < 3000; i++) send(i[0] ? 1'b0 : 1'b1);
    finish_pattern("R8", 3);
    chk(max_out <= 4 && min_out >= -4, "R8 alternating max", max_out, 0);
    chk(n_out >= 10, "R8 output count", n_out, 17);

    do_reset();
    // R7: three-quarter density
    for (int i = 0; i < 3000; i++) send((i % 4) != 3);
    finish_pattern("R7", 4);
    chk(last_out == 16384, "R7 1,1,1,0 value", last_out, 16384);

    do_reset();
    // R1: pseudo-random bits with idle gaps carrying junk
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[3] | lfsr[7]);
      if (lfsr[5:4] == 2'b00) idle(1 + lfsr[9:8]);
    end
    finish_pattern("R1", 5);
    chk(n_out >= 20, "R1 outputs with gaps", n_out, 25);

    do_reset();
    // R9: same stream after reset reproduces same outputs (model restarted)
    for (int i = 0; i < 3000; i++) send(1'b1);
    finish_pattern("R9", 6);
    chk(last_out == 32767, "R9 repeat after reset", last_out, 32767);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule